// File: doc/BRIEF.md
# CAN Fault Confinement Unit with Test Overrides

This block keeps the two error counters of a CAN node, one for transmission faults and one for reception faults. From their values it derives the node's fault-confinement state: error active, error passive or bus-off. The bit-level protocol engine sends it single-cycle event strobes. There is one strobe for each kind of error and one for each kind of successful frame. The unit updates the counters on the next clock edge.

A seven-bit test-control word adds several overrides for bring-up and self-test:

- Counter freeze.
- A forced error-passive state.
- A test path that writes one value into both counters in the same cycle.
- A self-acknowledge request that drives the ACK slot of the node's own frames.
- Routing between the engine's TX/RX bits and the device pins, for internal-loop or external-bus self-test.

The counter and threshold logic uses registers. The pin routing and the acknowledge request are purely combinational.

Top module: `can_fault_guard`

## Requirements
- R1: After a synchronous active-low reset, the test-control word reads 0, both counters read 0, and the state is error active (`st_active`=1, `st_passive`=0, `st_busoff`=0).
- R2: A write strobe `cfg_wr` stores `cfg_wdata` into the test-control word, and `cfg_rdata` returns it on the next cycle. The field positions are:
  - bit0: freeze
  - bit1: force passive
  - bit2: counter-write enable
  - bit3: auto-acknowledge
  - bit4: loop enable
  - bit5: TX output off
  - bit6: RX input off
- R3: When counters are not frozen or loaded, `ev_tx_err` adds 8 to `tec` and saturates at 511. `ev_tx_ok` subtracts 1 and never goes below 0. If both strobes are high in the same cycle, the error wins.
- R4: When counters are not frozen or loaded, `ev_rx_err` adds 1 to `rec` and saturates at 511. `ev_rx_ok` subtracts 1 and never goes below 0. If both strobes are high in the same cycle, the error wins.
- R5: While bit0 is 1, `tec` and `rec` keep their values and ignore all four event strobes.
- R6: While bit2 is 1, a `cnt_wr` strobe loads `cnt_wdata` into both `tec` and `rec` on the same edge.
  - The load takes priority over events and over freeze.
  - While bit2 is 0, `cnt_wr` has no effect.
- R7: The state flags follow the counters:
  - Bus-off when `tec` > 255.
  - Otherwise error passive when `tec` > 127 or `rec` > 127.
  - Otherwise error active.
  - Exactly one flag is high at any time.
- R8: While bit1 is 1, the node reports error passive whatever the counters hold, unless it is bus-off. Bus-off takes priority.
- R9: `ack_drive` equals `ack_slot` while bit3 is 1, and is 0 while bit3 is 0.
- R10: `pin_tx` is held at 1 (recessive) while bit5 is 1, and equals `eng_tx` otherwise.
- R11: `eng_rx` is the AND of two terms:
  - the pin term: `pin_rx`, or 1 while bit6 is 1;
  - the loop term: `eng_tx` while bit4 is 1, or 1 otherwise.

  So with bits 4, 5 and 6 all at 1, TX feeds RX internally and the pins are isolated. With all three at 0, the engine sees the bus directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_tx_err | input | 1 | Transmit error event strobe |
| ev_rx_err | input | 1 | Receive error event strobe |
| ev_tx_ok | input | 1 | Successful transmit strobe |
| ev_rx_ok | input | 1 | Successful receive strobe |
| cfg_wr | input | 1 | Test-control word write strobe |
| cfg_wdata | input | 7 | Test-control word write data |
| cfg_rdata | output | 7 | Test-control word readback |
| cnt_wr | input | 1 | Shared counter write strobe |
| cnt_wdata | input | 9 | Value loaded into both counters |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| st_active | output | 1 | Error-active flag |
| st_passive | output | 1 | Error-passive flag |
| st_busoff | output | 1 | Bus-off flag |
| ack_slot | input | 1 | Engine marks the ACK slot of an own frame |
| ack_drive | output | 1 | Request to drive a dominant acknowledge |
| eng_tx | input | 1 | TX bit from the protocol engine |
| eng_rx | output | 1 | RX bit delivered to the protocol engine |
| pin_tx | output | 1 | TX device pin |
| pin_rx | input | 1 | RX device pin |

## Verification
The hardest states to reach from the ports are the upper thresholds. Bus-off needs 32 unanswered transmit errors. Saturation at 511 needs 64. Random event streams alone rarely get there. The counter sweeps therefore use the shared counter-write path to drop both counters at random points across the full 9-bit range, and then run a biased event stream from there. This reaches saturation, the 127/255 boundaries and floor-at-zero cases under every combination of freeze, load enable and forced passive. The routing is swept over all 128 combinations of the three routing bits, auto-acknowledge, ack slot, engine TX and pin RX.

// File: rtl/can_fc_pkg.sv
// Package: shared types for the CAN fault-confinement unit.
// Assumes: the test-control word is seven bits, freeze in bit 0.
package can_fc_pkg;

    localparam int CTRL_W = 7;

    // Test-control word, packed so that bit 0 is freeze.
    typedef struct packed {
        logic rx_off;        // bit6
        logic tx_off;        // bit5
        logic loop_en;       // bit4
        logic auto_ack;      // bit3
        logic cnt_wr_en;     // bit2
        logic force_passive; // bit1
        logic freeze;        // bit0
    } tst_ctrl_t;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

endpackage

// File: rtl/fc_err_counter.sv
// Module: one saturating error counter.
// Up adds STEP (saturating at all-ones), down subtracts 1 (floor 0).
// A load overrides everything. Freeze blocks the event updates only.
// Assumes: up and down may be high together; up wins.
module fc_err_counter #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         up,
    input  logic         down,
    output logic [W-1:0] cnt
);
    localparam logic [W:0] STEP_X = (W+1)'(STEP);

    logic [W:0] sum;

    // Widened sum, so that saturation is detected by the carry bit.
    always_comb sum = {1'b0, cnt} + STEP_X;

    // Counter register: load, then frozen hold, then up/down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (!freeze) begin
            if (up) begin
                cnt <= sum[W] ? '1 : sum[W-1:0];
            end else if (down && (cnt != '0)) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/fc_state_decode.sv
// Module: maps counter values to the fault-confinement state.
// Bus-off beats the forced-passive override, which beats error active.
// Assumes: the limits fit in W bits.
module fc_state_decode
    import can_fc_pkg::*;
#(
    parameter int W        = 9,
    parameter int PASS_LIM = 127,
    parameter int BOFF_LIM = 255
) (
    input  logic [W-1:0] tec,
    input  logic [W-1:0] rec,
    input  logic         force_passive,
    output logic         st_active,
    output logic         st_passive,
    output logic         st_busoff
);
    localparam logic [W-1:0] P_LIM = W'(PASS_LIM);
    localparam logic [W-1:0] B_LIM = W'(BOFF_LIM);

    fc_state_e state;

    // State select, in priority order.
    always_comb begin
        if (tec > B_LIM)
            state = FC_BUSOFF;
        else if (force_passive || (tec > P_LIM) || (rec > P_LIM))
            state = FC_PASSIVE;
        else
            state = FC_ACTIVE;
    end

    // One-hot flag outputs.
    always_comb begin
        st_active  = (state == FC_ACTIVE);
        st_passive = (state == FC_PASSIVE);
        st_busoff  = (state == FC_BUSOFF);
    end
endmodule

// File: rtl/fc_loop_route.sv
// Module: TX/RX pin routing and the self-acknowledge request.
// Dominant is 0, so merging two bit sources is a wired-AND.
// Assumes: every input is already synchronous to the engine's bit clock.
module fc_loop_route (
    input  logic tx_off,
    input  logic rx_off,
    input  logic loop_en,
    input  logic auto_ack,
    input  logic ack_slot,
    input  logic eng_tx,
    input  logic pin_rx,
    output logic pin_tx,
    output logic eng_rx,
    output logic ack_drive
);
    logic rx_pin_term;
    logic rx_loop_term;

    // TX pin is forced recessive when TX output is off.
    always_comb pin_tx = tx_off ? 1'b1 : eng_tx;

    // RX path: the pin term and the loop term are merged dominant-wins.
    always_comb begin
        rx_pin_term  = rx_off  ? 1'b1 : pin_rx;
        rx_loop_term = loop_en ? eng_tx : 1'b1;
        eng_rx       = rx_pin_term & rx_loop_term;
    end

    // Self-acknowledge request, only inside the ACK slot of own frames.
    always_comb ack_drive = auto_ack & ack_slot;
endmodule

// File: rtl/can_fault_guard.sv
// Module: top of the CAN fault-confinement unit with test overrides.
// Holds the test-control word and both error counters, decodes the
// state and routes the TX/RX pins.
// Assumes: the event strobes last one cycle each.
module can_fault_guard
    import can_fc_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int TX_STEP  = 8,
    parameter int RX_STEP  = 1,
    parameter int PASS_LIM = 127,
    parameter int BOFF_LIM = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_err,
    input  logic              ev_rx_err,
    input  logic              ev_tx_ok,
    input  logic              ev_rx_ok,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  tec,
    output logic [CNT_W-1:0]  rec,
    output logic              st_active,
    output logic              st_passive,
    output logic              st_busoff,
    input  logic              ack_slot,
    output logic              ack_drive,
    input  logic              eng_tx,
    output logic              eng_rx,
    output logic              pin_tx,
    input  logic              pin_rx
);
    tst_ctrl_t ctrl;
    logic      shared_load;

    // Test-control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl <= '0;
        else if (cfg_wr) ctrl <= tst_ctrl_t'(cfg_wdata);
    end

    // Readback and the gated shared-write strobe.
    always_comb begin
        cfg_rdata   = ctrl;
        shared_load = cnt_wr & ctrl.cnt_wr_en;
    end

    fc_err_counter #(.W(CNT_W), .STEP(TX_STEP)) u_tec (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (ctrl.freeze),
        .load     (shared_load),
        .load_val (cnt_wdata),
        .up       (ev_tx_err),
        .down     (ev_tx_ok),
        .cnt      (tec)
    );

    fc_err_counter #(.W(CNT_W), .STEP(RX_STEP)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (ctrl.freeze),
        .load     (shared_load),
        .load_val (cnt_wdata),
        .up       (ev_rx_err),
        .down     (ev_rx_ok),
        .cnt      (rec)
    );

    fc_state_decode #(.W(CNT_W), .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)) u_state (
        .tec           (tec),
        .rec           (rec),
        .force_passive (ctrl.force_passive),
        .st_active     (st_active),
        .st_passive    (st_passive),
        .st_busoff     (st_busoff)
    );

    fc_loop_route u_route (
        .tx_off    (ctrl.tx_off),
        .rx_off    (ctrl.rx_off),
        .loop_en   (ctrl.loop_en),
        .auto_ack  (ctrl.auto_ack),
        .ack_slot  (ack_slot),
        .eng_tx    (eng_tx),
        .pin_rx    (pin_rx),
        .pin_tx    (pin_tx),
        .eng_rx    (eng_rx),
        .ack_drive (ack_drive)
    );
endmodule

// File: rtl/can_fault_guard_chk.sv
// Checker: temporal properties of can_fault_guard, observed at its ports.
// Assumes: the default parameter layout of the test-control word.
module can_fault_guard_chk #(
    parameter int CNT_W    = 9,
    parameter int BOFF_LIM = 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_tx_err,
    input logic             ev_tx_ok,
    input logic             ev_rx_err,
    input logic             ev_rx_ok,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [6:0]       cfg_rdata,
    input logic [CNT_W-1:0] tec,
    input logic [CNT_W-1:0] rec,
    input logic             st_active,
    input logic             st_passive,
    input logic             st_busoff,
    input logic             ack_slot,
    input logic             ack_drive,
    input logic             pin_tx
);
    localparam logic [CNT_W-1:0] TOP8 = {CNT_W{1'b1}} - CNT_W'(8);
    localparam logic [CNT_W-1:0] BLIM = CNT_W'(BOFF_LIM);

    logic ld;
    always_comb ld = cnt_wr & cfg_rdata[2];

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] && !ld |=> (tec == $past(tec)) && (rec == $past(rec))); // R5
    AST_SHARED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (tec == $past(cnt_wdata)) && (rec == $past(cnt_wdata))); // R6
    AST_TEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_err && !cfg_rdata[0] && !ld && (tec <= TOP8) |=> tec == $past(tec) + CNT_W'(8)); // R3
    AST_TEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_ok && !ev_tx_err && !ld && (tec == '0) |=> tec == '0); // R3
    AST_REC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ok && !ev_rx_err && !ld && (rec == '0) |=> rec == '0); // R4
    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({st_active, st_passive, st_busoff})); // R7
    AST_BUSOFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tec > BLIM) |-> st_busoff && !st_passive); // R7
    AST_FORCE_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[1] && !st_busoff |-> st_passive); // R8
    AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |-> cfg_rdata[3] && ack_slot); // R9
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[5] |-> pin_tx); // R10
endmodule

bind can_fault_guard can_fault_guard_chk #(.CNT_W(CNT_W), .BOFF_LIM(BOFF_LIM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_tx_err  (ev_tx_err),
    .ev_tx_ok   (ev_tx_ok),
    .ev_rx_err  (ev_rx_err),
    .ev_rx_ok   (ev_rx_ok),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .cfg_rdata  (cfg_rdata),
    .tec        (tec),
    .rec        (rec),
    .st_active  (st_active),
    .st_passive (st_passive),
    .st_busoff  (st_busoff),
    .ack_slot   (ack_slot),
    .ack_drive  (ack_drive),
    .pin_tx     (pin_tx)
);

// File: tb/can_fault_guard_bench.sv
// Bench: sweeps over reset, control readback, the counter and state
// behaviour under every mix of control bits, and exhaustive pin routing.
module can_fault_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_tx_err = 0, ev_rx_err = 0, ev_tx_ok = 0, ev_rx_ok = 0;
    logic       cfg_wr = 0;
    logic [6:0] cfg_wdata = '0;
    logic [6:0] cfg_rdata;
    logic       cnt_wr = 0;
    logic [8:0] cnt_wdata = '0;
    logic [8:0] tec, rec;
    logic       st_active, st_passive, st_busoff;
    logic       ack_slot = 0, ack_drive;
    logic       eng_tx = 1, eng_rx, pin_tx, pin_rx = 1;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    can_fault_guard u_can_fault_guard (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_err(ev_tx_err), .ev_rx_err(ev_rx_err),
        .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .tec(tec), .rec(rec),
        .st_active(st_active), .st_passive(st_passive), .st_busoff(st_busoff),
        .ack_slot(ack_slot), .ack_drive(ack_drive),
        .eng_tx(eng_tx), .eng_rx(eng_rx), .pin_tx(pin_tx), .pin_rx(pin_rx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [6:0] v);
        cfg_wdata = v;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // Expected state code: 0 active, 1 passive, 2 bus-off.
    function automatic int exp_state(input int t, input int r, input bit frc);
        if (t > 255) return 2;
        if (frc || t > 127 || r > 127) return 1;
        return 0;
    endfunction

    function automatic int got_state();
        return {29'd0, st_busoff, st_passive, st_active} == 32'd4 ? 2 :
               {29'd0, st_busoff, st_passive, st_active} == 32'd2 ? 1 :
               {29'd0, st_busoff, st_passive, st_active} == 32'd1 ? 0 : 9;
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        int          t_exp, r_exp;
        logic [6:0]  phases [5];
        phases[0] = 7'b0000100;  // load enabled
        phases[1] = 7'b0000000;  // load disabled
        phases[2] = 7'b0000101;  // freeze + load
        phases[3] = 7'b0000001;  // freeze only
        phases[4] = 7'b0000110;  // forced passive + load
        lfsr = 16'hACE1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cfg_rdata == 7'd0, "R1 ctrl", int'(cfg_rdata), 0);
        check(tec == 9'd0, "R1 tec", int'(tec), 0);
        check(rec == 9'd0, "R1 rec", int'(rec), 0);
        check(got_state() == 0, "R1 state", got_state(), 0);

        // R2: readback of every control value
        for (int v = 0; v < 128; v++) begin
            write_cfg(7'(v));
            check(cfg_rdata == 7'(v), "R2 readback", int'(cfg_rdata), v);
        end
        write_cfg(7'd0);

        // R3..R8: counter and state sweeps per control phase
        t_exp = 0;
        r_exp = 0;
        for (int p = 0; p < 5; p++) begin
            write_cfg(phases[p]);
            for (int i = 0; i < 700; i++) begin
                bit ld, frz;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                ev_tx_err = (lfsr[1:0] == 2'b00);
                ev_tx_ok  = lfsr[2];
                ev_rx_err = lfsr[3] & lfsr[4];
                ev_rx_ok  = lfsr[5];
                cnt_wr    = (lfsr[10:6] == 5'd0);
                cnt_wdata = {lfsr[15:11], lfsr[3:0]};
                ld  = cnt_wr && phases[p][2];
                frz = phases[p][0];
                if (ld) begin
                    t_exp = int'(cnt_wdata);
                    r_exp = int'(cnt_wdata);
                end else if (!frz) begin
                    if (ev_tx_err)                 t_exp = (t_exp > 503) ? 511 : t_exp + 8;
                    else if (ev_tx_ok && t_exp > 0) t_exp = t_exp - 1;
                    if (ev_rx_err)                 r_exp = (r_exp > 510) ? 511 : r_exp + 1;
                    else if (ev_rx_ok && r_exp > 0) r_exp = r_exp - 1;
                end
                @(negedge clk);
                // R3 R5 R6: transmit counter; R4 R5 R6: receive counter
                check(int'(tec) == t_exp, "R3/R5/R6 tec", int'(tec), t_exp);
                check(int'(rec) == r_exp, "R4/R5/R6 rec", int'(rec), r_exp);
                // R7 R8: state flags
                check(got_state() == exp_state(t_exp, r_exp, phases[p][1]),
                      "R7/R8 state", got_state(), exp_state(t_exp, r_exp, phases[p][1]));
            end
            ev_tx_err = 0; ev_tx_ok = 0; ev_rx_err = 0; ev_rx_ok = 0; cnt_wr = 0;
        end

        // R8 with R7: bus-off beats forced passive
        write_cfg(7'b0000110);
        cnt_wdata = 9'd300;
        cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
        check(got_state() == 2, "R8 busoff priority", got_state(), 2);
        cnt_wdata = 9'd5;
        cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
        check(got_state() == 1, "R8 forced passive", got_state(), 1);

        // R9 R10 R11: exhaustive routing sweep
        for (int m = 0; m < 16; m++) begin
            write_cfg({m[3:1], m[0], 3'b000});
            for (int s = 0; s < 8; s++) begin
                bit exp_ack, exp_ptx, exp_rx;
                ack_slot = s[0];
                eng_tx   = s[1];
                pin_rx   = s[2];
                #1;
                exp_ack = m[0] & s[0];
                exp_ptx = m[2] ? 1'b1 : s[1];
                exp_rx  = (m[3] ? 1'b1 : s[2]) & (m[1] ? s[1] : 1'b1);
                check(ack_drive == exp_ack, "R9 ack_drive", int'(ack_drive), int'(exp_ack));
                check(pin_tx == exp_ptx, "R10 pin_tx", int'(pin_tx), int'(exp_ptx));
                check(eng_rx == exp_rx, "R11 eng_rx", int'(eng_rx), int'(exp_rx));
                @(negedge clk);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule